// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of page translations. Every entry maps a virtual page number to a physical frame. Each entry also carries three permission bits and an address-space identifier, so translations from several processes can live side by side. A lookup compares the requested page and the current address space against all entries at once. In the same cycle it reports a hit with the frame number and a permission verdict, or a miss. The miss handler lives outside the block. After a miss it walks its tables and installs the result through the fill port.

Fill is a valid/ready stream. A fill transfers on a clock edge where `fill_valid` and `fill_ready` are both high, and the new entry is visible to lookups from the next cycle. `fill_ready` drops in two cases: while a maintenance operation is on `mnt_op`, and when no slot can take the entry, meaning every slot is valid and locked and none holds the same mapping. The producer must then hold its request; nothing is queued. The maintenance pins are plain controls that act in one cycle: drop one mapping, drop one address space, or drop everything. Entries installed with the lock flag survive both replacement and the bulk flushes. Entries installed with the global flag match every address space.

Top module: `asid_tlb`

## Requirements
- R1: With `lk_valid` high, exactly one of `lk_hit` and `lk_miss` is high in the same cycle. A hit means some valid entry holds `lk_vpn` and either carries `lk_asid` or is global. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R2: A non-global entry never hits for a lookup whose `lk_asid` differs from its own identifier.
- R3: An entry filled with `fill_global` = 1 hits for its page under any `lk_asid`.
- R4: On a hit, `lk_ppn` is the entry's frame; with no hit, `lk_ppn` is zero. `lk_fault` is high on a hit when any of these holds: a read (`lk_write` = 0) to an entry without read permission; a write (`lk_write` = 1) to an entry without write permission; a user-mode access (`lk_user` = 1) to an entry without user permission.
- R5: An accepted fill first removes every valid entry that would collide with it. An entry collides when it has the same page and either has the same identifier or one of the two is global. The new mapping goes into the lowest-indexed such slot, so a lookup never sees two matching entries.
- R6: With no collision, a fill takes the lowest-indexed invalid slot. If every slot is valid, it takes the first unlocked slot at or after a round-robin pointer, wrapping past the last slot. The pointer starts at slot 0 after reset and moves to the slot after the victim only when it chose that victim.
- R7: `mnt_op` = 3 clears every unlocked entry in one cycle. Locked entries stay valid.
- R8: `mnt_op` = 2 clears, in one cycle, every entry that is unlocked, not global and tagged `mnt_asid`. All other entries stay.
- R9: `mnt_op` = 1 clears the entry that a lookup of `mnt_vpn` under `mnt_asid` would hit, even if it is locked.
- R10: `fill_ready` is low whenever `mnt_op` is nonzero, or when every slot is valid and locked and none collides with the fill. A fill presented while `fill_ready` is low changes nothing.
- R11: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| lk_user | input | 1 | 1 = user-mode access |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_fault | output | 1 | Hit, but permissions deny the access |
| lk_ppn | output | PPN_W | Physical frame of the hit entry |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | VPN_W | Page of the new mapping |
| fill_asid | input | ASID_W | Identifier of the new mapping |
| fill_ppn | input | PPN_W | Frame of the new mapping |
| fill_rd_ok | input | 1 | Read permitted |
| fill_wr_ok | input | 1 | Write permitted |
| fill_user_ok | input | 1 | User-mode access permitted |
| fill_global | input | 1 | Mapping matches every identifier |
| fill_lock | input | 1 | Pin the entry against eviction and bulk flush |
| mnt_op | input | 2 | 0 none, 1 drop one mapping, 2 drop an identifier, 3 drop all unlocked |
| mnt_vpn | input | VPN_W | Page for a single drop |
| mnt_asid | input | ASID_W | Identifier for a single drop or an identifier flush |

## Verification
The bench looks for the cases where replacement and tagging fall out of step. A global mapping filled over pages held by several identifiers must clear all of them; a design that clears only one leaves a stale entry that hits alongside the new one. Once the buffer is full, an eviction must skip locked slots. If it does not, a pinned mapping disappears; if the pointer moves wrongly, a later lookup hits a page the model has already dropped. It checks that the identifier flush spares global and locked entries, that a single drop removes even a locked entry, and that a fill presented against a full, all-locked buffer is refused rather than quietly overwriting a slot.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    MNT_NONE      = 2'd0,
    MNT_DROP_ONE  = 2'd1,
    MNT_DROP_ASID = 2'd2,
    MNT_DROP_ALL  = 2'd3
  } mnt_op_e;

  typedef struct packed {
    logic user_ok;
    logic wr_ok;
    logic rd_ok;
  } perm_t;

  localparam int PERM_W = 3;
endpackage

// File: rtl/asid_tlb_cam.sv
// Parallel tag compare over every slot.
module asid_tlb_cam #(
  parameter int N    = 48,
  parameter int VW   = 20,
  parameter int AW   = 8
) (
  input  logic [N-1:0]  valid_q,
  input  logic [N-1:0]  global_q,
  input  logic [VW-1:0] vpn_q [N],
  input  logic [AW-1:0] asid_q [N],
  input  logic [VW-1:0] key_vpn,
  input  logic [AW-1:0] key_asid,
  input  logic          key_any_asid,
  output logic [N-1:0]  match
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign match[g] = valid_q[g] && (vpn_q[g] == key_vpn) &&
                      (global_q[g] || key_any_asid || (asid_q[g] == key_asid));
  end
endmodule

// File: rtl/asid_tlb_sel.sv
// AND-OR select driven by a one-hot (or empty) vector.
module asid_tlb_sel #(
  parameter int N = 48,
  parameter int W = 16
) (
  input  logic [N-1:0] sel,
  input  logic [W-1:0] data [N],
  output logic [W-1:0] q
);
  always_comb begin
    q = '0;
    for (int i = 0; i < N; i++) begin
      q = q | (data[i] & {W{sel[i]}});
    end
  end
endmodule

// File: rtl/asid_tlb_victim.sv
// Slot choice for a fill: colliding slot, else first empty, else round-robin unlocked.
module asid_tlb_victim #(
  parameter int N  = 48,
  parameter int IW = 6
) (
  input  logic [N-1:0]  collide,
  input  logic [N-1:0]  valid_q,
  input  logic [N-1:0]  locked_q,
  input  logic [IW-1:0] rr_q,
  output logic [IW-1:0] slot,
  output logic          slot_ok,
  output logic          from_rr
);
  logic [IW-1:0] rr_slot, free_slot, hit_slot;
  logic          rr_ok, free_ok, hit_ok;

  always_comb begin
    rr_slot = '0;
    rr_ok   = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = int'(rr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!locked_q[idx]) begin
        rr_slot = IW'(idx);
        rr_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    free_slot = '0;
    free_ok   = 1'b0;
    hit_slot  = '0;
    hit_ok    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_slot = IW'(i);
        free_ok   = 1'b1;
      end
      if (collide[i]) begin
        hit_slot = IW'(i);
        hit_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    from_rr = 1'b0;
    if (hit_ok) begin
      slot    = hit_slot;
      slot_ok = 1'b1;
    end else if (free_ok) begin
      slot    = free_slot;
      slot_ok = 1'b1;
    end else begin
      slot    = rr_slot;
      slot_ok = rr_ok;
      from_rr = rr_ok;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_rd_ok,
  input  logic              fill_wr_ok,
  input  logic              fill_user_ok,
  input  logic              fill_global,
  input  logic              fill_lock,
  input  logic [1:0]        mnt_op,
  input  logic [VPN_W-1:0]  mnt_vpn,
  input  logic [ASID_W-1:0] mnt_asid
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  // entry state
  logic [ENTRIES-1:0] valid_q, locked_q, global_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IW-1:0]      rr_q;

  mnt_op_e op;
  assign op = mnt_op_e'(mnt_op);

  // ---------------- lookup ----------------
  logic [ENTRIES-1:0] lk_hits;
  logic [PPN_W-1:0]   sel_ppn;
  logic [PERM_W-1:0]  sel_perm;
  perm_t              hit_perm;
  logic               any_hit;

  asid_tlb_cam #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) u_lk_cam (
    .valid_q(valid_q), .global_q(global_q), .vpn_q(vpn_q), .asid_q(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .key_any_asid(1'b0), .match(lk_hits)
  );

  asid_tlb_sel #(.N(ENTRIES), .W(PPN_W)) u_ppn_sel (
    .sel(lk_hits), .data(ppn_q), .q(sel_ppn)
  );

  asid_tlb_sel #(.N(ENTRIES), .W(PERM_W)) u_perm_sel (
    .sel(lk_hits), .data(perm_q), .q(sel_perm)
  );

  assign any_hit  = |lk_hits;
  assign hit_perm = perm_t'(sel_perm);
  assign lk_hit   = lk_valid && any_hit;
  assign lk_miss  = lk_valid && !any_hit;
  assign lk_ppn   = lk_hit ? sel_ppn : '0;
  assign lk_fault = lk_hit && (( lk_write && !hit_perm.wr_ok) ||
                               (!lk_write && !hit_perm.rd_ok) ||
                               ( lk_user  && !hit_perm.user_ok));

  // ---------------- maintenance match ----------------
  logic [ENTRIES-1:0] drop_hits;
  logic [ENTRIES-1:0] asid_tag;

  asid_tlb_cam #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) u_drop_cam (
    .valid_q(valid_q), .global_q(global_q), .vpn_q(vpn_q), .asid_q(asid_q),
    .key_vpn(mnt_vpn), .key_asid(mnt_asid), .key_any_asid(1'b0), .match(drop_hits)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_asid_tag
    assign asid_tag[g] = (asid_q[g] == mnt_asid);
  end

  // ---------------- fill ----------------
  logic [ENTRIES-1:0] collide;
  logic [IW-1:0]      slot;
  logic               slot_ok, from_rr, fill_fire;

  asid_tlb_cam #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) u_fill_cam (
    .valid_q(valid_q), .global_q(global_q), .vpn_q(vpn_q), .asid_q(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .key_any_asid(fill_global),
    .match(collide)
  );

  asid_tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .collide(collide), .valid_q(valid_q), .locked_q(locked_q), .rr_q(rr_q),
    .slot(slot), .slot_ok(slot_ok), .from_rr(from_rr)
  );

  assign fill_ready = (op == MNT_NONE) && slot_ok;
  assign fill_fire  = fill_valid && fill_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      locked_q <= '0;
      global_q <= '0;
      rr_q     <= '0;
    end else begin
      unique case (op)
        MNT_DROP_ONE:  valid_q <= valid_q & ~drop_hits;
        MNT_DROP_ASID: valid_q <= valid_q & ~(asid_tag & ~locked_q & ~global_q);
        MNT_DROP_ALL:  valid_q <= valid_q & locked_q;
        default: begin
          if (fill_fire) begin
            valid_q        <= (valid_q & ~collide) | (ENTRIES'(1) << slot);
            locked_q[slot] <= fill_lock;
            global_q[slot] <= fill_global;
            if (from_rr) rr_q <= (slot == LAST) ? '0 : slot + 1'b1;
          end
        end
      endcase
    end
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      vpn_q[slot]  <= fill_vpn;
      asid_q[slot] <= fill_asid;
      ppn_q[slot]  <= fill_ppn;
      perm_q[slot] <= {fill_user_ok, fill_wr_ok, fill_rd_ok};
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         lk_hit,
  input logic         lk_miss,
  input logic         lk_fault,
  input logic [N-1:0] lk_hits,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] locked_q,
  input logic [1:0]   mnt_op,
  input logic         fill_ready
);
  AST_LOOKUP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R1
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits)); // R5
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit); // R4
  AST_MAINT_STALLS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op != 2'd0) |-> !fill_ready); // R10
  AST_FLUSH_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == 2'd3) |=> (valid_q == $past(valid_q & locked_q))); // R7
  AST_ASID_FLUSH_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == 2'd2) |=> ((valid_q & locked_q) == $past(valid_q & locked_q))); // R8
endmodule

bind asid_tlb asid_tlb_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_hits(lk_hits),
  .valid_q(valid_q), .locked_q(locked_q), .mnt_op(mnt_op),
  .fill_ready(fill_ready)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  localparam int N  = 48;
  localparam int VW = 20;
  localparam int PW = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic lk_hit, lk_miss, lk_fault, fill_ready;
  logic [PW-1:0] lk_ppn;
  logic fill_valid = 0, fill_rd_ok = 0, fill_wr_ok = 0, fill_user_ok = 0;
  logic fill_global = 0, fill_lock = 0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [1:0] mnt_op = 2'd0;
  logic [VW-1:0] mnt_vpn = '0;
  logic [AW-1:0] mnt_asid = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .ASID_W(AW)) i_asid_tlb (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_write, .lk_user,
    .lk_hit, .lk_miss, .lk_fault, .lk_ppn, .fill_valid, .fill_ready,
    .fill_vpn, .fill_asid, .fill_ppn, .fill_rd_ok, .fill_wr_ok,
    .fill_user_ok, .fill_global, .fill_lock, .mnt_op, .mnt_vpn, .mnt_asid
  );

  // behavioural reference
  bit m_v[N], m_lk[N], m_gl[N], m_r[N], m_w[N], m_u[N];
  int m_vpn[N], m_asid[N], m_ppn[N];
  int m_rr = 0;

  function automatic int m_find(int vpn, int asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_gl[i] || m_asid[i] == asid)) return i;
    return -1;
  endfunction

  function automatic bit m_collide(int i);
    return m_v[i] && m_vpn[i] == int'(fill_vpn) &&
           (m_gl[i] || fill_global || m_asid[i] == int'(fill_asid));
  endfunction

  function automatic bit m_ready();
    if (mnt_op != 2'd0) return 0;
    for (int i = 0; i < N; i++)
      if (m_collide(i) || !m_v[i] || !m_lk[i]) return 1;
    return 0;
  endfunction

  task automatic m_step();
    if (mnt_op == 2'd1) begin
      int e;
      e = m_find(int'(mnt_vpn), int'(mnt_asid));
      if (e >= 0) m_v[e] = 0;
    end else if (mnt_op == 2'd2) begin
      for (int i = 0; i < N; i++)
        if (!m_lk[i] && !m_gl[i] && m_asid[i] == int'(mnt_asid)) m_v[i] = 0;
    end else if (mnt_op == 2'd3) begin
      for (int i = 0; i < N; i++) if (!m_lk[i]) m_v[i] = 0;
    end else if (fill_valid && m_ready()) begin
      int s;
      bit rr;
      s = -1;
      rr = 0;
      for (int i = 0; i < N; i++) if (s < 0 && m_collide(i)) s = i;
      for (int i = 0; i < N; i++) if (m_collide(i)) m_v[i] = 0;
      if (s < 0) for (int i = 0; i < N; i++) if (s < 0 && !m_v[i]) s = i;
      if (s < 0) begin
        for (int k = 0; k < N; k++)
          if (s < 0 && !m_lk[(m_rr + k) % N]) s = (m_rr + k) % N;
        rr = 1;
      end
      m_v[s] = 1; m_lk[s] = fill_lock; m_gl[s] = fill_global;
      m_vpn[s] = int'(fill_vpn); m_asid[s] = int'(fill_asid);
      m_ppn[s] = int'(fill_ppn);
      m_r[s] = fill_rd_ok; m_w[s] = fill_wr_ok; m_u[s] = fill_user_ok;
      if (rr) m_rr = (s + 1) % N;
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string pick(string t, string d);
    return (t == "") ? d : t;
  endfunction

  // one clock: compare outputs mid-cycle, then advance design and model
  task automatic cyc(string tag);
    int e;
    bit eh, em, ef;
    int ep;
    #1;
    e  = lk_valid ? m_find(int'(lk_vpn), int'(lk_asid)) : -1;
    eh = lk_valid && e >= 0;
    em = lk_valid && e < 0;
    ef = eh && ((lk_write && !m_w[e]) || (!lk_write && !m_r[e]) || (lk_user && !m_u[e]));
    ep = eh ? m_ppn[e] : 0;
    check(pick(tag, "R1"), "hit", int'(lk_hit), int'(eh));
    check(pick(tag, "R1"), "miss", int'(lk_miss), int'(em));
    check(pick(tag, "R4"), "fault", int'(lk_fault), int'(ef));
    check(pick(tag, "R4"), "ppn", int'(lk_ppn), ep);
    check(pick(tag, "R10"), "fill_ready", int'(fill_ready), int'(m_ready()));
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; mnt_op = 2'd0;
    lk_write = 0; lk_user = 0; fill_global = 0; fill_lock = 0;
  endtask

  task automatic do_fill(int vpn, int asid, int ppn, bit r, bit w, bit u,
                         bit g, bit lk, string tag);
    idle();
    fill_valid = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid);
    fill_ppn = PW'(ppn); fill_rd_ok = r; fill_wr_ok = w; fill_user_ok = u;
    fill_global = g; fill_lock = lk;
    cyc(tag);
    idle();
  endtask

  task automatic do_look(int vpn, int asid, bit wr, bit usr, string tag);
    idle();
    lk_valid = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid);
    lk_write = wr; lk_user = usr;
    cyc(tag);
    idle();
  endtask

  task automatic do_mnt(int op, int vpn, int asid, string tag);
    idle();
    mnt_op = 2'(op); mnt_vpn = VW'(vpn); mnt_asid = AW'(asid);
    cyc(tag);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: empty after reset
    do_look(0, 0, 0, 0, "R11");
    do_look(5, 3, 1, 1, "R11");

    // R1 / R4: basic hit, permissions
    do_fill('h10, 1, 'h111, 1, 0, 1, 0, 0, "R6");
    do_look('h10, 1, 0, 0, "R1");
    do_look('h10, 1, 1, 0, "R4");
    do_look('h10, 1, 0, 1, "R4");
    do_fill('h11, 1, 'h123, 0, 1, 0, 0, 0, "R6");
    do_look('h11, 1, 0, 0, "R4");
    do_look('h11, 1, 1, 1, "R4");

    // R2: other identifier misses
    do_look('h10, 2, 0, 0, "R2");

    // R3: global matches any identifier
    do_fill('h20, 3, 'h333, 1, 1, 1, 1, 0, "R3");
    do_look('h20, 7, 0, 0, "R3");
    do_look('h20, 200, 1, 1, "R3");

    // R5: refill replaces; single drop then leaves nothing behind
    do_fill('h10, 1, 'h222, 1, 1, 1, 0, 0, "R5");
    do_look('h10, 1, 1, 0, "R5");
    do_mnt(1, 'h10, 1, "R9");
    do_look('h10, 1, 0, 0, "R5");
    // R5: global fill over two identifiers' copies
    do_fill('h60, 1, 'h61, 1, 1, 1, 0, 0, "R5");
    do_fill('h60, 2, 'h62, 1, 1, 1, 0, 0, "R5");
    do_fill('h60, 9, 'h69, 1, 1, 1, 1, 0, "R5");
    do_look('h60, 1, 0, 0, "R5");
    do_look('h60, 2, 0, 0, "R5");

    // R7: full flush keeps locked
    do_fill('h30, 1, 'h303, 1, 1, 0, 0, 1, "R7");
    do_mnt(3, 0, 0, "R7");
    do_look('h30, 1, 0, 0, "R7");
    do_look('h20, 1, 0, 0, "R7");
    // R9: single drop removes a locked entry
    do_mnt(1, 'h30, 1, "R9");
    do_look('h30, 1, 0, 0, "R9");

    // R8: identifier flush
    do_fill('h40, 4, 'h404, 1, 1, 1, 0, 0, "R8");
    do_fill('h41, 5, 'h415, 1, 1, 1, 0, 0, "R8");
    do_fill('h42, 4, 'h424, 1, 1, 1, 1, 0, "R8");
    do_fill('h43, 4, 'h434, 1, 1, 1, 0, 1, "R8");
    do_mnt(2, 0, 4, "R8");
    do_look('h40, 4, 0, 0, "R8");
    do_look('h41, 5, 0, 0, "R8");
    do_look('h42, 4, 0, 0, "R8");
    do_look('h43, 4, 0, 0, "R8");
    do_mnt(1, 'h43, 4, "R9");

    // R6: fill to capacity, then round-robin skipping a locked slot
    do_mnt(3, 0, 0, "R7");
    do_fill('h50, 0, 'h500, 1, 1, 1, 0, 1, "R6");
    for (int i = 1; i < N; i++) do_fill('h100 + i, 0, i, 1, 1, 1, 0, 0, "R6");
    do_fill('h200, 0, 'h2000, 1, 1, 1, 0, 0, "R6");
    do_look('h101, 0, 0, 0, "R6");
    do_look('h102, 0, 0, 0, "R6");
    do_look('h50, 0, 0, 0, "R6");
    do_fill('h201, 0, 'h2001, 1, 1, 1, 0, 0, "R6");
    do_look('h102, 0, 0, 0, "R6");
    do_look('h103, 0, 0, 0, "R6");

    // R10: maintenance blocks a fill
    idle();
    fill_valid = 1; fill_vpn = VW'('h300); fill_asid = '0; fill_ppn = PW'(7);
    fill_rd_ok = 1; mnt_op = 2'd1; mnt_vpn = VW'('h999);
    cyc("R10");
    idle();
    do_look('h300, 0, 0, 0, "R10");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      lk_valid = $urandom_range(0, 1) == 1;
      lk_vpn = VW'($urandom_range(0, 63));
      lk_asid = AW'($urandom_range(0, 3));
      lk_write = $urandom_range(0, 1) == 1;
      lk_user = $urandom_range(0, 1) == 1;
      fill_valid = $urandom_range(0, 1) == 1;
      fill_vpn = VW'($urandom_range(0, 63));
      fill_asid = AW'($urandom_range(0, 3));
      fill_ppn = PW'($urandom_range(0, 65535));
      fill_rd_ok = $urandom_range(0, 1) == 1;
      fill_wr_ok = $urandom_range(0, 1) == 1;
      fill_user_ok = $urandom_range(0, 1) == 1;
      fill_global = $urandom_range(0, 9) == 0;
      fill_lock = $urandom_range(0, 49) == 0;
      r = $urandom_range(0, 99);
      if (r < 8) mnt_op = 2'd1;
      else if (r < 11) mnt_op = 2'd2;
      else if (r < 12) mnt_op = 2'd3;
      mnt_vpn = VW'($urandom_range(0, 63));
      mnt_asid = AW'($urandom_range(0, 3));
      cyc("");
    end

    // R10: all slots locked, a new fill is refused
    idle();
    for (int i = 0; i < N; i++) begin
      mnt_op = 2'd1; mnt_vpn = VW'(i); mnt_asid = '0;
      cyc("R9");
    end
    for (int i = 0; i < 64; i++) begin
      mnt_op = 2'd1; mnt_vpn = VW'(i); mnt_asid = AW'(i % 4);
      cyc("R9");
      mnt_op = 2'd1; mnt_vpn = VW'(i); mnt_asid = AW'((i + 1) % 4);
      cyc("R9");
      mnt_op = 2'd1; mnt_vpn = VW'(i); mnt_asid = AW'((i + 2) % 4);
      cyc("R9");
      mnt_op = 2'd1; mnt_vpn = VW'(i); mnt_asid = AW'((i + 3) % 4);
      cyc("R9");
    end
    idle();
    for (int i = 0; i < N; i++) do_fill('h400 + i, 6, i, 1, 1, 1, 0, 1, "R10");
    do_fill('h500, 6, 'h55, 1, 1, 1, 0, 0, "R10");
    do_look('h500, 6, 0, 0, "R10");
    do_look('h400, 6, 0, 0, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule